// File: doc/BRIEF.md
# Multiplexed LCD Common/Segment Sequencer

This block sequences the four common lines and thirty-two segment lines of a multiplexed liquid-crystal panel. On every pulse of a slow scan tick, taken from a 32768 Hz time base, it moves to the next active common. It drives that common to the selected extreme rail and drives each segment to an "on" or "off" level according to the pattern held for that common. Every output is a 2-bit rail code: 2'b00 = VSS, 2'b01 = VDD1, 2'b10 = VDD2, 2'b11 = VDD. The analog rails themselves are generated outside the block.

A frame sweeps the active commons twice. The first pass uses positive polarity and the second uses negative polarity, so no pixel sees a net DC voltage. The duty select sets how many commons take part: 2'b00 gives 1/2 duty, 2'b01 gives 1/3 duty, and 2'b10 or 2'b11 gives 1/4 duty. The bias select picks 1/2 bias (`bias_third` = 0) or 1/3 bias (`bias_third` = 1). A host writes the four 32-bit row patterns through a small write port, using the index `pat_addr`.

The block has two refresh modes. In shared mode, `svc_strobe` pulses at every common step, and `cur_com` tells firmware which common is now active so that it can reload that row. In automatic mode, scanning waits until the host writes the configuration once (`cfg_wr`); after that, scanning runs on its own.

The sequencer is a three-state machine:
- IDLE: blank panel, every pin at VSS.
- POS: positive pass.
- NEG: negative pass.

Its transitions are:
- start: IDLE to POS when the run condition holds.
- pos_wrap: POS to NEG on a tick at the last active common.
- neg_wrap: NEG to POS on a tick at the last active common.
- stop: any state to IDLE when the run condition fails.
- step: a tick at any other common stays in the same state and advances the index.

Top module: `lcd_scan_seq`

## Requirements
- R1: While reset is held, every common and segment code is 2'b00 (VSS), `cur_com` is 0 and `svc_strobe` is 0.
- R2: With `shared_mode` = 0, the panel stays blank at VSS, even with `disp_en` = 1 and ticks arriving, until `cfg_wr` has been pulsed. After that pulse, scanning starts at common 0 in the positive pass two clocks later.
- R3: Each `scan_tick` seen at a clock edge advances `cur_com` by one. After the last active common (index 1, 2 or 3 for duty codes 2'b00, 2'b01 and 2'b1x), it wraps to 0. `cur_com` changes at no other time except a return to 0.
- R4: A wrap from the last common flips the pass polarity. The first pass after start is positive.
- R5: With 1/2 bias, the selected common is VDD in the positive pass and VSS in the negative pass. Unselected active commons are VDD2. An "on" segment (pattern bit 1) is VSS in the positive pass and VDD in the negative pass. An "off" segment is VDD in the positive pass and VSS in the negative pass. VDD1 is never driven.
- R6: With 1/3 bias, the selected common is VDD in the positive pass and VSS in the negative pass. Unselected active commons are VDD1 in the positive pass and VDD2 in the negative pass. An "on" segment is VSS in the positive pass and VDD in the negative pass. An "off" segment is VDD2 in the positive pass and VDD1 in the negative pass.
- R7: Bit k of segment pin k comes from the pattern row whose index equals `cur_com`. A write with `pat_wr` = 1 stores `pat_wdata` into row `pat_addr`.
- R8: Commons whose index is above the last active common stay at VSS while scanning.
- R9: In shared mode, `svc_strobe` is high for exactly the one cycle after each tick that steps the scan. In automatic mode it stays 0.
- R10: When `disp_en` is 0 at a clock edge, every output returns to VSS and `cur_com` to 0 by the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_tick | input | 1 | One-cycle step pulse from the 32768 Hz divider |
| disp_en | input | 1 | Display on |
| shared_mode | input | 1 | 1 = software refresh with service strobe |
| cfg_wr | input | 1 | Configuration write pulse; arms automatic refresh |
| duty_sel | input | 2 | 00 = 1/2, 01 = 1/3, 1x = 1/4 duty |
| bias_third | input | 1 | 0 = 1/2 bias, 1 = 1/3 bias |
| pat_wr | input | 1 | Pattern row write enable |
| pat_addr | input | 2 | Pattern row index (common number) |
| pat_wdata | input | 32 | Pattern row data, 1 = segment on |
| com_lvl | output | 8 | Rail code per common, common i in bits [2i+1:2i] |
| seg_lvl | output | 64 | Rail code per segment, segment k in bits [2k+1:2k] |
| cur_com | output | 2 | Common now being served |
| svc_strobe | output | 1 | Shared-mode service pulse |

## Verification
The assertions check the following on every cycle:
- A blank panel follows a cleared enable.
- No more than one common sits at VDD at a time.
- The VDD1 rail never appears under 1/2 bias.
- The common index moves only on a tick or a return to zero.
- The service strobe follows only a tick in shared mode.

The bench's scenarios are needed for the rest: the exact rail code on each pin for every duty, bias and polarity combination, the polarity flip at each wrap, segment data taken from the correct row, and the arming of automatic mode by the configuration write.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
    typedef enum logic [1:0] {
        LV_VSS  = 2'b00,
        LV_VDD1 = 2'b01,
        LV_VDD2 = 2'b10,
        LV_VDD  = 2'b11
    } lvl_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_POS  = 2'b01,
        ST_NEG  = 2'b10
    } scan_st_e;
endpackage

// File: rtl/lcd_pat_regs.sv
module lcd_pat_regs #(
    parameter int N_COM = 4,
    parameter int N_SEG = 32,
    localparam int COM_W = $clog2(N_COM)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [COM_W-1:0] addr,
    input  logic [N_SEG-1:0] wdata,
    input  logic [COM_W-1:0] rd_idx,
    output logic [N_SEG-1:0] rd_row
);
    logic [N_SEG-1:0] rows [N_COM];

    for (genvar r = 0; r < N_COM; r++) begin : g_row
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                rows[r] <= '0;
            else if (wr && addr == COM_W'(r))
                rows[r] <= wdata;
        end
    end

    assign rd_row = rows[rd_idx];
endmodule

// File: rtl/lcd_scan_fsm.sv
module lcd_scan_fsm
    import lcd_scan_pkg::*;
#(
    parameter int N_COM = 4,
    localparam int COM_W = $clog2(N_COM)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_tick,
    input  logic             disp_en,
    input  logic             shared_mode,
    input  logic             cfg_wr,
    input  logic [COM_W-1:0] duty_sel,
    output scan_st_e         state,
    output logic [COM_W-1:0] com_idx,
    output logic [COM_W-1:0] last_idx,
    output logic             strobe
);
    scan_st_e         nxt_state;
    logic [COM_W-1:0] nxt_idx;
    logic             armed;
    logic             run_ok;
    logic             at_last;
    logic             stepping;

    always_comb begin
        if (32'(duty_sel) + 1 >= N_COM)
            last_idx = COM_W'(N_COM - 1);
        else
            last_idx = duty_sel + COM_W'(1);
    end

    assign run_ok   = disp_en && (shared_mode || armed);
    assign at_last  = com_idx >= last_idx;
    assign stepping = run_ok && scan_tick && (state != ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (cfg_wr)
            armed <= 1'b1;
    end

    always_comb begin
        nxt_state = state;
        nxt_idx   = com_idx;
        if (!run_ok) begin
            nxt_state = ST_IDLE;
            nxt_idx   = '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    nxt_state = ST_POS;
                    nxt_idx   = '0;
                end
                ST_POS: if (scan_tick) begin
                    if (at_last) begin
                        nxt_state = ST_NEG;
                        nxt_idx   = '0;
                    end else begin
                        nxt_idx = com_idx + COM_W'(1);
                    end
                end
                ST_NEG: if (scan_tick) begin
                    if (at_last) begin
                        nxt_state = ST_POS;
                        nxt_idx   = '0;
                    end else begin
                        nxt_idx = com_idx + COM_W'(1);
                    end
                end
                default: begin
                    nxt_state = ST_IDLE;
                    nxt_idx   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            com_idx <= '0;
            strobe  <= 1'b0;
        end else begin
            state   <= nxt_state;
            com_idx <= nxt_idx;
            strobe  <= stepping && shared_mode;
        end
    end
endmodule

// File: rtl/lcd_level_map.sv
module lcd_level_map
    import lcd_scan_pkg::*;
#(
    parameter int N_COM = 4,
    parameter int N_SEG = 32,
    localparam int COM_W = $clog2(N_COM)
) (
    input  scan_st_e           state,
    input  logic               bias_third,
    input  logic [COM_W-1:0]   com_idx,
    input  logic [COM_W-1:0]   last_idx,
    input  logic [N_SEG-1:0]   row,
    output logic [2*N_COM-1:0] com_lvl,
    output logic [2*N_SEG-1:0] seg_lvl
);
    logic  neg;
    lvl_e  c_sel, c_unsel, s_on, s_off;

    assign neg = (state == ST_NEG);

    always_comb begin
        c_sel   = neg ? LV_VSS : LV_VDD;
        s_on    = neg ? LV_VDD : LV_VSS;
        if (bias_third) begin
            c_unsel = neg ? LV_VDD2 : LV_VDD1;
            s_off   = neg ? LV_VDD1 : LV_VDD2;
        end else begin
            c_unsel = LV_VDD2;
            s_off   = neg ? LV_VSS : LV_VDD;
        end
    end

    for (genvar c = 0; c < N_COM; c++) begin : g_com
        always_comb begin
            if (state == ST_IDLE || COM_W'(c) > last_idx)
                com_lvl[2*c +: 2] = LV_VSS;
            else if (COM_W'(c) == com_idx)
                com_lvl[2*c +: 2] = c_sel;
            else
                com_lvl[2*c +: 2] = c_unsel;
        end
    end

    for (genvar s = 0; s < N_SEG; s++) begin : g_seg
        always_comb begin
            if (state == ST_IDLE)
                seg_lvl[2*s +: 2] = LV_VSS;
            else
                seg_lvl[2*s +: 2] = row[s] ? s_on : s_off;
        end
    end
endmodule

// File: rtl/lcd_scan_seq.sv
module lcd_scan_seq
    import lcd_scan_pkg::*;
#(
    parameter int N_COM = 4,
    parameter int N_SEG = 32,
    localparam int COM_W = $clog2(N_COM)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scan_tick,
    input  logic               disp_en,
    input  logic               shared_mode,
    input  logic               cfg_wr,
    input  logic [COM_W-1:0]   duty_sel,
    input  logic               bias_third,
    input  logic               pat_wr,
    input  logic [COM_W-1:0]   pat_addr,
    input  logic [N_SEG-1:0]   pat_wdata,
    output logic [2*N_COM-1:0] com_lvl,
    output logic [2*N_SEG-1:0] seg_lvl,
    output logic [COM_W-1:0]   cur_com,
    output logic               svc_strobe
);
    scan_st_e         state;
    logic [COM_W-1:0] last_idx;
    logic [N_SEG-1:0] row;

    lcd_scan_fsm #(.N_COM(N_COM)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .disp_en(disp_en),
        .shared_mode(shared_mode), .cfg_wr(cfg_wr), .duty_sel(duty_sel),
        .state(state), .com_idx(cur_com), .last_idx(last_idx), .strobe(svc_strobe)
    );

    lcd_pat_regs #(.N_COM(N_COM), .N_SEG(N_SEG)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(pat_wr), .addr(pat_addr),
        .wdata(pat_wdata), .rd_idx(cur_com), .rd_row(row)
    );

    lcd_level_map #(.N_COM(N_COM), .N_SEG(N_SEG)) u_map (
        .state(state), .bias_third(bias_third), .com_idx(cur_com),
        .last_idx(last_idx), .row(row), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );
endmodule

// File: rtl/lcd_scan_chk.sv
module lcd_scan_chk #(
    parameter int N_COM = 4,
    parameter int N_SEG = 32,
    localparam int COM_W = $clog2(N_COM)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               scan_tick,
    input logic               disp_en,
    input logic               shared_mode,
    input logic               bias_third,
    input logic [2*N_COM-1:0] com_lvl,
    input logic [2*N_SEG-1:0] seg_lvl,
    input logic [COM_W-1:0]   cur_com,
    input logic               svc_strobe
);
    logic [N_COM-1:0] com_top;
    logic             any_mid_low;

    always_comb begin
        any_mid_low = 1'b0;
        for (int c = 0; c < N_COM; c++) begin
            com_top[c] = (com_lvl[2*c +: 2] == 2'b11);
            if (com_lvl[2*c +: 2] == 2'b01) any_mid_low = 1'b1;
        end
        for (int s = 0; s < N_SEG; s++)
            if (seg_lvl[2*s +: 2] == 2'b01) any_mid_low = 1'b1;
    end

    // R10
    blank_after_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_en |=> (com_lvl == '0 && seg_lvl == '0 && cur_com == '0));

    // R5
    one_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(com_top) <= 1);

    // R5
    no_vdd1_half_bias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bias_third |-> !any_mid_low);

    // R3
    index_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_com != $past(cur_com)) |-> ($past(scan_tick) || cur_com == '0));

    // R9
    strobe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_strobe |-> ($past(scan_tick) && $past(shared_mode)));

    // R9
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_strobe && !scan_tick |=> !svc_strobe);
endmodule

bind lcd_scan_seq lcd_scan_chk #(.N_COM(N_COM), .N_SEG(N_SEG)) u_chk (
    .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .disp_en(disp_en),
    .shared_mode(shared_mode), .bias_third(bias_third), .com_lvl(com_lvl),
    .seg_lvl(seg_lvl), .cur_com(cur_com), .svc_strobe(svc_strobe)
);

// File: tb/tb_lcd_scan_seq.sv
`timescale 1ns/1ps
module tb_lcd_scan_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scan_tick = 1'b0, disp_en = 1'b0, shared_mode = 1'b0, cfg_wr = 1'b0;
    logic [1:0]  duty_sel = 2'd3;
    logic        bias_third = 1'b0;
    logic        pat_wr = 1'b0;
    logic [1:0]  pat_addr = '0;
    logic [31:0] pat_wdata = '0;
    logic [7:0]  com_lvl;
    logic [63:0] seg_lvl;
    logic [1:0]  cur_com;
    logic        svc_strobe;

    int tests = 0, fails = 0;
    bit done = 0;

    logic [31:0] pats [4];

    always #2.5 clk = ~clk;

    lcd_scan_seq dut (.*);

    // vector: bias_third, duty_sel, ticks, expected com, expected negative pass
    typedef struct packed {
        logic       b3;
        logic [1:0] duty;
        logic [3:0] ticks;
        logic [1:0] ecom;
        logic       eneg;
    } vec_t;
    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 4'd0, 2'd0, 1'b0}, '{1'b0, 2'd0, 4'd1, 2'd1, 1'b0},
        '{1'b0, 2'd0, 4'd2, 2'd0, 1'b1}, '{1'b0, 2'd0, 4'd3, 2'd1, 1'b1},
        '{1'b0, 2'd0, 4'd4, 2'd0, 1'b0}, '{1'b1, 2'd1, 4'd2, 2'd2, 1'b0},
        '{1'b1, 2'd1, 4'd3, 2'd0, 1'b1}, '{1'b1, 2'd1, 4'd5, 2'd2, 1'b1},
        '{1'b1, 2'd2, 4'd3, 2'd3, 1'b0}, '{1'b1, 2'd2, 4'd4, 2'd0, 1'b1},
        '{1'b0, 2'd2, 4'd6, 2'd2, 1'b1}, '{1'b1, 2'd3, 4'd7, 2'd3, 1'b1}
    };

    function automatic logic [7:0] exp_com(input logic b3, input logic [1:0] duty,
                                           input logic [1:0] c, input logic neg);
        int last = (duty == 2'd0) ? 1 : (duty == 2'd1) ? 2 : 3;
        logic [7:0] v = '0;
        for (int i = 0; i < 4; i++) begin
            if (i > last)           v[2*i +: 2] = 2'b00;
            else if (i == int'(c))  v[2*i +: 2] = neg ? 2'b00 : 2'b11;
            else if (b3)            v[2*i +: 2] = neg ? 2'b10 : 2'b01;
            else                    v[2*i +: 2] = 2'b10;
        end
        return v;
    endfunction

    function automatic logic [63:0] exp_seg(input logic b3, input logic [31:0] p,
                                            input logic neg);
        logic [63:0] v;
        for (int k = 0; k < 32; k++) begin
            if (p[k])     v[2*k +: 2] = neg ? 2'b11 : 2'b00;
            else if (b3)  v[2*k +: 2] = neg ? 2'b01 : 2'b10;
            else          v[2*k +: 2] = neg ? 2'b00 : 2'b11;
        end
        return v;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick_once();
        scan_tick = 1'b1;
        @(negedge clk);
        scan_tick = 1'b0;
    endtask

    task automatic write_row(input logic [1:0] a, input logic [31:0] d);
        pat_wr = 1'b1; pat_addr = a; pat_wdata = d;
        @(negedge clk);
        pat_wr = 1'b0;
        pats[a] = d;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: state during reset
        check("R1 com", {56'd0, com_lvl}, '0);
        check("R1 seg", seg_lvl, '0);
        check("R1 idx/strobe", {61'd0, cur_com, svc_strobe}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        write_row(2'd0, 32'hA5A5_0F0F);
        write_row(2'd1, 32'h1234_5678);
        write_row(2'd2, 32'hFFFF_0000);
        write_row(2'd3, 32'h8000_0001);

        // R2: automatic mode, not yet armed
        disp_en = 1'b1;
        @(negedge clk);
        tick_once();
        @(negedge clk);
        check("R2 blank before arm", {com_lvl, seg_lvl[55:0]}, '0);
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        @(negedge clk);
        check("R2 started com", {56'd0, com_lvl}, {56'd0, exp_com(1'b0, 2'd3, 2'd0, 1'b0)});

        // R3 R4 R5 R6 R7 R8: vector table
        for (int v = 0; v < NV; v++) begin
            disp_en = 1'b0;
            bias_third = VECS[v].b3;
            duty_sel = VECS[v].duty;
            @(negedge clk);
            disp_en = 1'b1;
            @(negedge clk);
            for (int t = 0; t < int'(VECS[v].ticks); t++) tick_once();
            check("R3 cur_com", {62'd0, cur_com}, {62'd0, VECS[v].ecom});
            check("R4/R5/R6/R8 com levels", {56'd0, com_lvl},
                  {56'd0, exp_com(VECS[v].b3, VECS[v].duty, VECS[v].ecom, VECS[v].eneg)});
            check("R7/R5/R6 seg levels", seg_lvl,
                  exp_seg(VECS[v].b3, pats[VECS[v].ecom], VECS[v].eneg));
        end

        // R7: rewrite current row while scanning
        write_row(cur_com, 32'h0000_FFFF);
        check("R7 rewritten row", seg_lvl, exp_seg(bias_third, 32'h0000_FFFF, 1'b1));

        // R9: no strobe in automatic mode
        tick_once();
        check("R9 auto no strobe", {63'd0, svc_strobe}, 64'd0);
        // R9: shared mode strobe, one cycle
        shared_mode = 1'b1;
        scan_tick = 1'b1;
        @(negedge clk);
        scan_tick = 1'b0;
        check("R9 strobe high", {63'd0, svc_strobe}, 64'd1);
        @(negedge clk);
        check("R9 strobe one cycle", {63'd0, svc_strobe}, 64'd0);

        // R10: display off
        disp_en = 1'b0;
        @(negedge clk);
        check("R10 blank", {com_lvl, seg_lvl[55:0]}, '0);
        check("R10 idx", {62'd0, cur_com}, 64'd0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule